// File: doc/BRIEF.md
# SD Card Bus Clock Divider

This block derives the card bus clock from a fixed functional reference clock. The division ratio is a 10-bit divisor. It comes from one of three preset target rates, or it is taken from a manual input. For a preset rate the divisor is the ceiling of the reference frequency over the target, so the card clock never runs faster than requested. Every divisor, preset or manual, is limited to the range 2 to 1023.

Two enables control the block. The internal enable starts the divider. While it is low the whole divider is held idle. The card enable only decides whether the divided clock reaches the card pin, and it takes effect only at a period boundary. A stable flag shows when the running divisor matches the requested one and has completed at least one full output period. Software or a sequencer should wait for this flag before it treats the card clock as usable. A one-cycle strobe marks each rising edge of the card clock, for logic in the reference domain that must act in step with the card clock.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is asserted and directly after it, `sd_clk`, `sd_clk_rise` and `clk_stable` are all 0.
- R2: `rate_sel` picks the divisor. Code 0 means manual, code 1 the identification rate (400 kHz), code 2 the normal rate (25 MHz) and code 3 the fast rate (50 MHz). A preset divisor is ceil(REF_HZ / target). With a 96 MHz reference this gives periods of 240, 4 and 2 reference cycles.
- R3: A divisor below 2 (manual values 0 or 1) runs as 2. The largest divisor, 1023, runs as 1023.
- R4: For a divisor N, each card clock period is high for ceil(N/2) reference cycles and low for floor(N/2), so an odd divisor gives the extra cycle to the high phase.
- R5: `sd_clk_rise` is high for exactly one reference cycle, in the same cycle that `sd_clk` goes from 0 to 1, and at no other time.
- R6: When the requested divisor changes in the middle of a period, that period completes with the old divisor. The new divisor applies from the next period.
- R7: `clk_stable` falls within one reference cycle after the requested divisor differs from the running one. It rises again at the end of the first full period run with the new divisor.
- R8: While `int_clk_en` is 0, `sd_clk` and `clk_stable` stay 0. After enabling, the first card clock rise comes one cycle later, and `clk_stable` rises together with the second rise.
- R9: While the card enable is 0 (as sampled at a period boundary), `sd_clk` stays 0. Turning the card enable on or off never shortens a high pulse: `sd_clk` changes only at period boundaries, or at the normal fall within a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Functional reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to ref_clk |
| int_clk_en | input | 1 | Enables the internal divider |
| card_clk_en | input | 1 | Lets the divided clock reach the card pin |
| rate_sel | input | 2 | Divisor source: 0 manual, 1 identification, 2 normal, 3 fast |
| div_manual | input | DIV_W | Manual divisor used when rate_sel is 0 |
| sd_clk | output | 1 | Card bus clock, driven from a register |
| sd_clk_rise | output | 1 | One-cycle strobe with each rising edge of sd_clk |
| clk_stable | output | 1 | Running divisor matches the request and has run a full period |

## Verification
Three groups of divisors are used. The three presets check the rounding-up calculation against the real reference frequency. Manual values 0, 1, 5, 9 and 1023 exercise the clamps and the high/low split for odd divisors, and each one is checked over several periods in a scoreboard. A divisor change made just after a rising edge shows whether the period in flight finishes with the old ratio, and the bench also checks where the stable flag falls and where it rises again. The card enable is dropped and raised in the middle of a period to show whether a pulse is ever cut short, and the internal enable is cycled to check the idle state and the start-up timing of the stable flag.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Ceiling quotient num/den, limited to [lo, hi].
  function automatic logic [31:0] ceil_clamp(longint unsigned num, longint unsigned den,
                                             int unsigned lo, int unsigned hi);
    longint unsigned q;
    q = (num + den - 64'd1) / den;
    if (q < longint'(lo)) q = longint'(lo);
    if (q > longint'(hi)) q = longint'(hi);
    return 32'(q);
  endfunction

  // Limit a raw divisor to [lo, hi].
  function automatic logic [31:0] clamp_div(logic [31:0] v, int unsigned lo, int unsigned hi);
    logic [31:0] r;
    r = v;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    return r;
  endfunction

  // Number of reference cycles in the high phase: odd divisors favour high.
  function automatic logic [31:0] high_len(logic [31:0] n);
    return (n + 32'd1) >> 1;
  endfunction

endpackage

// File: rtl/sdclk_div_select.sv
module sdclk_div_select #(
  parameter longint unsigned REF_HZ  = 96_000_000,
  parameter longint unsigned ID_HZ   = 400_000,
  parameter longint unsigned NORM_HZ = 25_000_000,
  parameter longint unsigned FAST_HZ = 50_000_000,
  parameter int unsigned     DIV_W   = 10,
  parameter int unsigned     DIV_MIN = 2
) (
  input  logic [1:0]       rate_sel,
  input  logic [DIV_W-1:0] div_manual,
  output logic [DIV_W-1:0] req_div
);
  localparam int unsigned DIV_MAX = (1 << DIV_W) - 1;
  localparam logic [DIV_W-1:0] DIV_ID   = DIV_W'(sdclk_pkg::ceil_clamp(REF_HZ, ID_HZ,   DIV_MIN, DIV_MAX));
  localparam logic [DIV_W-1:0] DIV_NORM = DIV_W'(sdclk_pkg::ceil_clamp(REF_HZ, NORM_HZ, DIV_MIN, DIV_MAX));
  localparam logic [DIV_W-1:0] DIV_FAST = DIV_W'(sdclk_pkg::ceil_clamp(REF_HZ, FAST_HZ, DIV_MIN, DIV_MAX));

  logic [DIV_W-1:0] manual_lim;

  always_comb begin
    manual_lim = DIV_W'(sdclk_pkg::clamp_div(32'(div_manual), DIV_MIN, DIV_MAX));
    unique case (rate_sel)
      2'd1:    req_div = DIV_ID;
      2'd2:    req_div = DIV_NORM;
      2'd3:    req_div = DIV_FAST;
      default: req_div = manual_lim;
    endcase
  end
endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned DIV_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             gate_en,
  input  logic [DIV_W-1:0] req_div,
  output logic             clk_out,
  output logic             rise_out,
  output logic             wrap_o,
  output logic [DIV_W-1:0] act_div_o
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] act_q, act_n;
  logic             gate_q, gate_n;
  logic             out_q, out_n;
  logic             rise_q, rise_n;
  logic             phase_n;
  logic             wrap_w;

  // End of the current output period.
  assign wrap_w = run && (cnt_q == act_q - DIV_W'(1));

  always_comb begin
    if (!run) begin
      // Idle: preload so that the first enabled edge starts a period.
      act_n  = req_div;
      cnt_n  = req_div - DIV_W'(1);
      gate_n = 1'b0;
    end else if (wrap_w) begin
      act_n  = req_div;
      cnt_n  = '0;
      gate_n = gate_en;
    end else begin
      act_n  = act_q;
      cnt_n  = cnt_q + DIV_W'(1);
      gate_n = gate_q;
    end
    phase_n = run && (cnt_n < DIV_W'(sdclk_pkg::high_len(32'(act_n))));
    out_n   = phase_n && gate_n;
    rise_n  = out_n && wrap_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= DIV_W'(DIV_MIN - 1);
      act_q  <= DIV_W'(DIV_MIN);
      gate_q <= 1'b0;
      out_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      gate_q <= gate_n;
      out_q  <= out_n;
      rise_q <= rise_n;
    end
  end

  assign clk_out   = out_q;
  assign rise_out  = rise_q;
  assign wrap_o    = wrap_w;
  assign act_div_o = act_q;

  // R3: the running divisor never drops under the floor.
  a_r3_act_floor: assert property (@(posedge clk) disable iff (!rst_n)
    act_q >= DIV_W'(DIV_MIN));
  // R6: inside a running period the divisor is held.
  a_r6_hold_div: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_w) |=> $stable(act_q));
  // R5: the strobe marks a true low-to-high step of the card clock.
  a_r5_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (out_q && !$past(out_q)));
  // R9: a rising card clock only ever starts at a period boundary.
  a_r9_rise_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(wrap_w));
  // R9: a closed gate keeps the card clock low.
  a_r9_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !out_q);
endmodule

// File: rtl/sdclk_stable_track.sv
module sdclk_stable_track #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic [DIV_W-1:0] req_div,
  input  logic [DIV_W-1:0] act_div,
  output logic             stable
);
  logic stable_q, primed_q;
  logic mismatch_w;

  assign mismatch_w = (req_div != act_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      primed_q <= 1'b0;
    end else if (!run) begin
      stable_q <= 1'b0;
      primed_q <= 1'b0;
    end else if (mismatch_w) begin
      stable_q <= 1'b0;
      if (wrap) primed_q <= 1'b1;
    end else if (wrap) begin
      stable_q <= primed_q;
      primed_q <= 1'b1;
    end
  end

  assign stable = stable_q;

  // R7: a divisor request that differs from the running one clears stable.
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mismatch_w) |=> !stable_q);
  // R8: an idle divider never reports stable.
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !stable_q);
  // R7: stable only rises at a period boundary.
  a_r7_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable_q) |-> $past(wrap));
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter longint unsigned REF_HZ  = 96_000_000,
  parameter longint unsigned ID_HZ   = 400_000,
  parameter longint unsigned NORM_HZ = 25_000_000,
  parameter longint unsigned FAST_HZ = 50_000_000,
  parameter int unsigned     DIV_W   = 10,
  parameter int unsigned     DIV_MIN = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             int_clk_en,
  input  logic             card_clk_en,
  input  logic [1:0]       rate_sel,
  input  logic [DIV_W-1:0] div_manual,
  output logic             sd_clk,
  output logic             sd_clk_rise,
  output logic             clk_stable
);
  logic [DIV_W-1:0] req_div_w;
  logic [DIV_W-1:0] act_div_w;
  logic             wrap_w;

  sdclk_div_select #(
    .REF_HZ(REF_HZ), .ID_HZ(ID_HZ), .NORM_HZ(NORM_HZ), .FAST_HZ(FAST_HZ),
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN)
  ) sel_i (
    .rate_sel  (rate_sel),
    .div_manual(div_manual),
    .req_div   (req_div_w)
  );

  sdclk_phase_gen #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) phase_i (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .run      (int_clk_en),
    .gate_en  (card_clk_en),
    .req_div  (req_div_w),
    .clk_out  (sd_clk),
    .rise_out (sd_clk_rise),
    .wrap_o   (wrap_w),
    .act_div_o(act_div_w)
  );

  sdclk_stable_track #(.DIV_W(DIV_W)) stab_i (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .run    (int_clk_en),
    .wrap   (wrap_w),
    .req_div(req_div_w),
    .act_div(act_div_w),
    .stable (clk_stable)
  );

  // R8: with the internal clock off the card pin is quiet.
  a_r8_pin_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !int_clk_en |=> !sd_clk);
  // R3: the requested divisor is always inside the legal range.
  a_r3_req_range: assert property (@(posedge ref_clk) disable iff (!rst_n)
    req_div_w >= DIV_W'(DIV_MIN));
endmodule

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb_top;
  localparam longint unsigned REF = 96_000_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_en = 1'b0;
  logic       card_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [9:0] man = 10'd5;
  logic       sd_clk, sd_rise, stable;

  int total = 0;
  int bad = 0;

  int    qn[$];
  string qt[$];
  bit    mon_on = 1'b0;
  bit    seen = 1'b0;
  bit    prev_clk = 1'b0;
  int    cyc = 0;
  int    hic = 0;

  always #4 clk = ~clk;

  sdclk_gen dut_i (
    .ref_clk(clk), .rst_n(rst_n), .int_clk_en(int_en), .card_clk_en(card_en),
    .rate_sel(sel), .div_manual(man),
    .sd_clk(sd_clk), .sd_clk_rise(sd_rise), .clk_stable(stable)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_preset(longint unsigned tgt);
    longint unsigned q;
    q = REF / tgt;
    if (REF % tgt != 0) q++;
    if (q < 2) q = 2;
    if (q > 1023) q = 1023;
    return int'(q);
  endfunction

  function automatic int exp_manual(int v);
    return (v < 2) ? 2 : v;
  endfunction

  // Monitor: measures each period between rises and compares with the queue.
  always @(negedge clk) begin
    if (!mon_on) begin
      seen = 1'b0;
    end else begin
      chk(sd_rise == (sd_clk && !prev_clk), "R5 strobe", int'(sd_rise), int'(sd_clk && !prev_clk));
      if (sd_clk && !prev_clk) begin
        if (seen && qn.size() > 0) begin
          int    e;
          string t;
          e = qn.pop_front();
          t = qt.pop_front();
          chk(cyc == e, {t, " period"}, cyc, e);
          chk(hic == (e + 1) / 2, "R4 high phase", hic, (e + 1) / 2);
        end
        seen = 1'b1;
        cyc = 0;
        hic = 0;
      end
      cyc++;
      if (sd_clk) hic++;
    end
    prev_clk = sd_clk;
  end

  task automatic wait_rise();
    do begin
      @(posedge clk);
      #1;
    end while (!sd_rise);
  endtask

  task automatic wait_stable();
    int n = 0;
    while (!stable && n < 5000) begin
      @(posedge clk);
      #1;
      n++;
    end
  endtask

  task automatic drain();
    while (qn.size() > 0) begin
      @(posedge clk);
      #1;
    end
    mon_on = 1'b0;
  endtask

  task automatic measure(input int n, input int k, input string tag);
    wait_stable();
    wait_rise();
    mon_on = 1'b1;
    for (int i = 0; i < k; i++) begin
      qn.push_back(n);
      qt.push_back(tag);
    end
    drain();
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi_run;
    bit extra;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(!sd_clk && !sd_rise && !stable, "R1 in reset", int'({sd_clk, sd_rise, stable}), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(!sd_clk && !sd_rise && !stable, "R1 after reset", int'({sd_clk, sd_rise, stable}), 0);

    // R8: idle divider stays quiet
    card_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!sd_clk && !stable, "R8 idle", int'({sd_clk, stable}), 0);
    end
    // R8: start-up timing of stable
    @(posedge clk);
    #1;
    int_en = 1'b1;
    wait_rise();
    chk(stable == 1'b0, "R8 stable at first rise", int'(stable), 0);
    wait_rise();
    chk(stable == 1'b1, "R8 stable at second rise", int'(stable), 1);

    // R4 with odd manual divisor, R2 presets
    measure(5, 3, "R4");
    sel = 2'd1; measure(exp_preset(400_000), 3, "R2 id rate");
    chk(exp_preset(400_000) == 240, "R2 id value", exp_preset(400_000), 240);
    sel = 2'd2; measure(exp_preset(25_000_000), 4, "R2 normal rate");
    sel = 2'd3; measure(exp_preset(50_000_000), 4, "R2 fast rate");

    // R3 clamps
    sel = 2'd0;
    man = 10'd0; measure(exp_manual(0), 4, "R3 zero");
    man = 10'd1; measure(exp_manual(1), 4, "R3 one");
    man = 10'd1023; measure(1023, 3, "R3 max");

    // R6/R7: change divisor just after a rise
    man = 10'd5;
    wait_stable();
    wait_rise();
    mon_on = 1'b1;
    qn.push_back(5); qt.push_back("R6 old period");
    qn.push_back(9); qt.push_back("R6 new period");
    qn.push_back(9); qt.push_back("R6 new period");
    man = 10'd9;
    @(posedge clk);
    #1;
    chk(stable == 1'b0, "R7 drop", int'(stable), 0);
    wait_rise();
    chk(stable == 1'b0, "R7 low at switch", int'(stable), 0);
    wait_rise();
    chk(stable == 1'b1, "R7 back after full period", int'(stable), 1);
    drain();

    // R9: drop card enable early in a high phase of divisor 9
    wait_rise();
    card_en = 1'b0;
    hi_run = 0;
    extra = 1'b0;
    // negedges from here: the current high phase (5 cycles) then silence
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i < 5) begin
        if (sd_clk) hi_run++;
      end else if (sd_clk || sd_rise) begin
        extra = 1'b1;
      end
    end
    chk(hi_run == 5, "R9 pulse kept whole", hi_run, 5);
    chk(!extra, "R9 gated low", int'(extra), 0);
    chk(stable == 1'b1, "R9 stable unaffected", int'(stable), 1);
    // re-open mid-period: next pulse must be whole
    card_en = 1'b1;
    while (!sd_clk) @(negedge clk);
    hi_run = 0;
    while (sd_clk) begin
      hi_run++;
      @(negedge clk);
    end
    chk(hi_run == 5, "R9 first pulse whole", hi_run, 5);

    // R8: disable returns to idle
    @(posedge clk);
    #1;
    int_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!sd_clk && !stable, "R8 off again", int'({sd_clk, stable}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule